// File: doc/BRIEF.md
# Sensor Data Capture Bank Buffer

This block holds the sensor data words received for a configurable number of serial slaves, one entry per slave, in register storage that a host reads through a small synchronous port. The transfer engine opens a cycle, writes each slave's data word with its received check bits by slave index, and then closes the cycle as complete or abandons it.

A mode input picks the buffering scheme. In paired mode there are two banks. One bank takes the writes of the running cycle while the host reads the other. The banks trade places only when a cycle completes, so the host always sees the last complete data set. In solo mode one bank serves both sides. The host must watch the busy flag so that it does not read a set that is only partly written. The received check bits can be kept in the upper bits of each entry. This happens only when checking is enabled, the polynomial setting is nonzero, and the suppress input is low.

Top module: `sdc_bank_buffer`

## Requirements
- R1: With `single_bank_i`=0, reads return the entries of the set closed by the most recent `cycle_done_i`. Writes from a running cycle are not visible to reads until that cycle completes.
- R2: With `single_bank_i`=1, writes and reads share one bank. A write is visible to a read issued on the cycle after the write edge, even while `busy_o` is high.
- R3: `busy_o` rises on the clock edge where `cycle_start_i` is seen while idle. It falls on the edge where `cycle_done_i` or `cycle_abort_i` is seen while busy.
- R4: With `single_bank_i`=0, a `cycle_done_i` accepted while busy (and without abort) exchanges the read and write banks. With `single_bank_i`=1 no exchange occurs.
- R5: `cycle_abort_i` ends the cycle without an exchange, and takes priority over a simultaneous `cycle_done_i`. Data written during the aborted cycle stays hidden from reads.
- R6: Entry layout: bits [DATA_W-1:0] hold the data word and bits [DATA_W+CRC_W-1:DATA_W] hold the check bits (DATA_W=16, CRC_W=6 by default).
- R7: The check bits are stored only when `no_crc_i`=0, `crc_check_en_i`=1 and `crc_poly_i`!=0. Otherwise those upper bits are written as zero.
- R8: `rd_data_o` is updated on the edge where `rd_en_i` is sampled high, and holds its value while `rd_en_i` is low.
- R9: A write while `busy_o` is low, or with `wr_idx_i` >= N_SLAVES, changes no entry. A read with `rd_idx_i` >= N_SLAVES returns zero.
- R10: After reset `busy_o`=0, `rd_data_o`=0 and every entry of both banks is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| single_bank_i | input | 1 | 0: paired banks, 1: one shared bank |
| no_crc_i | input | 1 | 1: do not store check bits |
| crc_check_en_i | input | 1 | Check-bit verification enabled |
| crc_poly_i | input | CRC_W | Configured polynomial, zero means none |
| cycle_start_i | input | 1 | Opens a capture cycle |
| cycle_done_i | input | 1 | Closes the cycle as complete |
| cycle_abort_i | input | 1 | Abandons the cycle |
| wr_valid_i | input | 1 | Write strobe from the transfer engine |
| wr_idx_i | input | $clog2(N_SLAVES) | Slave index of the write |
| wr_data_i | input | DATA_W | Received sensor data word |
| wr_crc_i | input | CRC_W | Received check bits |
| busy_o | output | 1 | A cycle is in progress |
| rd_en_i | input | 1 | Host read strobe |
| rd_idx_i | input | $clog2(N_SLAVES) | Slave index to read |
| rd_data_o | output | DATA_W+CRC_W | Read entry, registered |

## Verification
`busy_o` and the bank exchange take effect one edge after the start, done or abort strobe. A written entry can be read one edge after the write, and `rd_data_o` carries it one edge after `rd_en_i`. The bench drives every input 1 ns after a rising edge and samples 1 ns after the edge that follows, so each result is read in its first valid cycle. Reads issued before and after a done or abort strobe show whether the exchange happened on that edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic {
    CYC_IDLE = 1'b0,
    CYC_RUN  = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/sdc_cycle_ctrl.sv
module sdc_cycle_ctrl
  import sdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic single_bank_i,
  input  logic cycle_start_i,
  input  logic cycle_done_i,
  input  logic cycle_abort_i,
  output logic busy_o,
  output logic rd_bank_o,
  output logic wr_bank_o
);
  cyc_state_e state_q;
  logic       rd_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CYC_IDLE;
      rd_bank_q <= 1'b0;
    end else begin
      case (state_q)
        CYC_IDLE: if (cycle_start_i) state_q <= CYC_RUN;
        CYC_RUN: begin
          if (cycle_abort_i) begin
            state_q <= CYC_IDLE;
          end else if (cycle_done_i) begin
            state_q <= CYC_IDLE;
            if (!single_bank_i) rd_bank_q <= ~rd_bank_q;
          end
        end
        default: state_q <= CYC_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q == CYC_RUN);
  assign rd_bank_o = rd_bank_q;
  // solo mode: writes land in the bank the host reads
  assign wr_bank_o = single_bank_i ? rd_bank_q : ~rd_bank_q;

  a_r3_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cycle_start_i) |=> busy_o);
  a_r3_end_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (cycle_done_i || cycle_abort_i)) |=> !busy_o);
  a_r4_done_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cycle_done_i && !cycle_abort_i && !single_bank_i)
      |=> (rd_bank_o != $past(rd_bank_o)));
  a_r5_abort_keeps_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cycle_abort_i) |=> $stable(rd_bank_o));
  a_r1_banks_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !single_bank_i) |-> (wr_bank_o != rd_bank_o));
endmodule

// File: rtl/sdc_entry_fmt.sv
module sdc_entry_fmt #(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 6
) (
  input  logic                    no_crc_i,
  input  logic                    crc_check_en_i,
  input  logic [CRC_W-1:0]        crc_poly_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [CRC_W-1:0]        crc_i,
  output logic [DATA_W+CRC_W-1:0] entry_o
);
  logic keep_crc;

  assign keep_crc = !no_crc_i && crc_check_en_i && (|crc_poly_i);
  assign entry_o  = {(keep_crc ? crc_i : {CRC_W{1'b0}}), data_i};
endmodule

// File: rtl/sdc_bank_mem.sv
module sdc_bank_mem #(
  parameter int N_SLAVES = 5,
  parameter int ENTRY_W  = 22,
  parameter int IDX_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_bank_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ENTRY_W-1:0] wr_entry_i,
  input  logic               rd_en_i,
  input  logic               rd_bank_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  localparam int N_BANKS = 2;

  logic [ENTRY_W-1:0] mem_q [N_BANKS][N_SLAVES];
  logic [ENTRY_W-1:0] rd_word;
  logic [ENTRY_W-1:0] rd_data_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    for (genvar s = 0; s < N_SLAVES; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mem_q[b][s] <= '0;
        end else if (wr_en_i && (wr_bank_i == 1'(b)) && (wr_idx_i == IDX_W'(s))) begin
          mem_q[b][s] <= wr_entry_i;
        end
      end
    end
  end

  // out-of-range index reads as zero
  always_comb begin
    rd_word = '0;
    for (int s = 0; s < N_SLAVES; s++) begin
      if (rd_idx_i == IDX_W'(s)) rd_word = mem_q[rd_bank_i][s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_word;
  end

  assign rd_data_o = rd_data_q;

  a_r8_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  a_r9_rd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (int'(rd_idx_i) >= N_SLAVES)) |=> (rd_data_o == '0));
endmodule

// File: rtl/sdc_bank_buffer.sv
module sdc_bank_buffer #(
  parameter int N_SLAVES = 5,
  parameter int DATA_W   = 16,
  parameter int CRC_W    = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          single_bank_i,
  input  logic                          no_crc_i,
  input  logic                          crc_check_en_i,
  input  logic [CRC_W-1:0]              crc_poly_i,
  input  logic                          cycle_start_i,
  input  logic                          cycle_done_i,
  input  logic                          cycle_abort_i,
  input  logic                          wr_valid_i,
  input  logic [$clog2(N_SLAVES)-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [CRC_W-1:0]              wr_crc_i,
  output logic                          busy_o,
  input  logic                          rd_en_i,
  input  logic [$clog2(N_SLAVES)-1:0]   rd_idx_i,
  output logic [DATA_W+CRC_W-1:0]       rd_data_o
);
  localparam int ENTRY_W = DATA_W + CRC_W;
  localparam int IDX_W   = $clog2(N_SLAVES);

  logic               rd_bank;
  logic               wr_bank;
  logic               wr_en;
  logic [ENTRY_W-1:0] wr_entry;

  sdc_cycle_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .single_bank_i (single_bank_i),
    .cycle_start_i (cycle_start_i),
    .cycle_done_i  (cycle_done_i),
    .cycle_abort_i (cycle_abort_i),
    .busy_o        (busy_o),
    .rd_bank_o     (rd_bank),
    .wr_bank_o     (wr_bank)
  );

  sdc_entry_fmt #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_fmt (
    .no_crc_i       (no_crc_i),
    .crc_check_en_i (crc_check_en_i),
    .crc_poly_i     (crc_poly_i),
    .data_i         (wr_data_i),
    .crc_i          (wr_crc_i),
    .entry_o        (wr_entry)
  );

  // writes outside a cycle are dropped
  assign wr_en = wr_valid_i && busy_o;

  sdc_bank_mem #(.N_SLAVES(N_SLAVES), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_bank_i  (wr_bank),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .rd_en_i    (rd_en_i),
    .rd_bank_i  (rd_bank),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o)
  );

  a_r7_crc_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && (no_crc_i || !crc_check_en_i || (crc_poly_i == '0)))
      |-> (wr_entry[ENTRY_W-1:DATA_W] == '0));
endmodule

// File: tb/sdc_bank_buffer_tb.sv
module sdc_bank_buffer_tb_top;
  localparam int NS = 5;
  localparam int DW = 16;
  localparam int CW = 6;
  localparam int EW = DW + CW;
  localparam int NV = 6;

  localparam logic [15:0] V_DATA [NV] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'hA5A5, 16'hFFFF, 16'h0001};
  localparam logic [5:0]  V_CRC  [NV] = '{6'h2A, 6'h15, 6'h3F, 6'h01, 6'h3F, 6'h20};
  localparam logic        V_NOC  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic        V_EN   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [5:0]  V_POLY [NV] = '{6'h03, 6'h03, 6'h03, 6'h00, 6'h21, 6'h01};
  localparam logic [21:0] V_EXP  [NV] = '{22'h2A1234, 22'h00BEEF, 22'h000F0F, 22'h00A5A5, 22'h3FFFFF, 22'h200001};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_bank = 1'b0, no_crc = 1'b0, chk_en = 1'b0;
  logic [CW-1:0] poly = '0;
  logic c_start = 1'b0, c_done = 1'b0, c_abort = 1'b0;
  logic wr_valid = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] wr_crc = '0;
  logic busy;
  logic rd_en = 1'b0;
  logic [2:0] rd_idx = '0;
  logic [EW-1:0] rd_data;
  logic [EW-1:0] got;
  logic [EW-1:0] held;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdc_bank_buffer #(.N_SLAVES(NS), .DATA_W(DW), .CRC_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .single_bank_i(single_bank), .no_crc_i(no_crc),
    .crc_check_en_i(chk_en), .crc_poly_i(poly), .cycle_start_i(c_start),
    .cycle_done_i(c_done), .cycle_abort_i(c_abort), .wr_valid_i(wr_valid),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_crc_i(wr_crc), .busy_o(busy),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_cyc();
    c_start = 1'b1; tick(); c_start = 1'b0;
  endtask

  task automatic done_cyc();
    c_done = 1'b1; tick(); c_done = 1'b0;
  endtask

  task automatic put(input logic [2:0] idx, input logic [DW-1:0] d, input logic [CW-1:0] c);
    wr_valid = 1'b1; wr_idx = idx; wr_data = d; wr_crc = c;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic get(input logic [2:0] idx, output logic [EW-1:0] v);
    rd_en = 1'b1; rd_idx = idx;
    tick();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #5 rst_n = 1'b1;
    tick();
    // R10 reset state
    check("R10 busy", 32'(busy), 0);
    check("R10 rd_data", 32'(rd_data), 0);
    for (int i = 0; i < NS; i++) begin
      get(3'(i), got);
      check("R10 entry", 32'(got), 0);
    end

    // R3 busy timing
    start_cyc();
    check("R3 busy rise", 32'(busy), 1);
    done_cyc();
    check("R3 busy fall", 32'(busy), 0);
    // that empty cycle swapped once: rd bank 1, wr bank 0

    // R6/R7 vector walk in paired mode (R4 exchange makes data visible)
    for (int v = 0; v < NV; v++) begin
      no_crc = V_NOC[v]; chk_en = V_EN[v]; poly = V_POLY[v];
      start_cyc();
      put(3'(v % 4), V_DATA[v], V_CRC[v]);
      done_cyc();
      get(3'(v % 4), got);
      check("R6 R7 R4 vector", 32'(got), 32'(V_EXP[v]));
    end
    // cycles so far: empty->wr b1, v0 b0, v1 b1, v2 b0, v3 b1, v4 b0, v5 b1; rd bank now 1

    // R1 hidden until done
    no_crc = 1'b1;
    start_cyc();
    put(3'd0, 16'h5555, 6'h3F);
    get(3'd0, got);
    check("R1 hidden before done", 32'(got), 0);
    done_cyc();
    get(3'd0, got);
    check("R1 visible after done", 32'(got), 32'h005555);
    // rd bank now 0 (holds v0 idx0->5555, v2 idx2, v4 idx0 overwritten)

    // R5 abort: no exchange, partial data hidden, abort beats done
    start_cyc();
    put(3'd1, 16'h7777, 6'h00);
    c_abort = 1'b1; c_done = 1'b1; tick(); c_abort = 1'b0; c_done = 1'b0;
    check("R5 busy after abort", 32'(busy), 0);
    get(3'd0, got);
    check("R5 no exchange", 32'(got), 32'h005555);
    get(3'd1, got);
    check("R5 abort data hidden", 32'(got), 0);

    // R8 hold while rd_en low
    held = rd_data;
    rd_idx = 3'd0;
    tick(); tick();
    check("R8 hold", 32'(rd_data), 32'(held));

    // R2 solo mode, bank 0 shared
    single_bank = 1'b1;
    no_crc = 1'b0; chk_en = 1'b1; poly = 6'h05;
    put(3'd3, 16'h1111, 6'h00);  // idle write, R9
    get(3'd3, got);
    check("R9 idle write ignored", 32'(got), 0);
    start_cyc();
    get(3'd4, got);
    check("R2 before write", 32'(got), 0);
    put(3'd4, 16'h4444, 6'h05);
    get(3'd4, got);
    check("R2 visible mid-cycle", 32'(got), 32'h054444);
    check("R2 still busy", 32'(busy), 1);
    put(3'd5, 16'h9999, 6'h01);  // out of range, R9
    get(3'd1, got);
    check("R9 no alias on idx1", 32'(got), 0);
    get(3'd5, got);
    check("R9 out-of-range read", 32'(got), 0);
    done_cyc();
    check("R3 busy fall solo", 32'(busy), 0);
    get(3'd4, got);
    check("R4 no exchange solo", 32'(got), 32'h054444);
    get(3'd0, got);
    check("R2 shared bank", 32'(got), 32'h005555);

    finish_run();
  end
endmodule